// File: doc/BRIEF.md
# Clock Source Switch Controller

This block holds the control word that selects which of five clock source groups drives a small microcontroller, and it sequences changes between them. Software writes a requested source code and sets a switch-enable bit. The controller then waits until the target source has reported ready for a programmable number of consecutive cycles, and only then does it move the code into the read-only current-source field. Requests that name an unusable code, or the source already running, are dropped at once. The switch-enable bit always clears itself by hardware.

A fail-safe monitor input overrides everything else. It forces the current source to the internal fast RC group, latches a clock-fail flag and cancels any switch in flight. The controller also keeps a PLL lock status bit and drives a two-bit postscaler select together with its decoded divide ratio. The oscillators, the PLL and the glitch-free clock multiplexer live outside this block. They are seen here only as ready, lock and fail inputs.

Top module: `cksw_top`

## Requirements
- R1: While rstN is low, the current-source field (rdData[10:8]) and the requested-source field (rdData[2:0]) both take the value of cfgSrc. Switch-enable (bit 3), postscaler select (bits 5:4), clock-fail flag (bit 6) and lock status (bit 7) are all cleared.
- R2: Bits 15:11 of rdData always read 0. A write to bit 7 or to bits 10:8 does not change them.
- R3: A write takes effect only when wrEn is high and byteEn[0] is high. byteEn[0] covers the writable bits 6:0. The upper byte holds no writable state.
- R4: Source codes are 000 low-power crystal, 001 fast RC, 010 low-power RC, 011 external, 111 PLL. Codes 100, 101 and 110 are invalid. A switch request for an invalid code, or for the code already current, aborts: switch-enable clears on the next clock edge and the current source does not change.
- R5: A valid switch request starts on the first edge after switch-enable is set. The current source takes the target code on the SETTLE_CYCLES-th consecutive edge at which srcReady[target] is high, and switch-enable clears on that same edge. A cycle with ready low restarts the count.
- R6: A clkFail high at an edge forces the current source to 001, sets the clock-fail flag and cancels a pending switch, which clears switch-enable. No later ready cycles complete the cancelled switch.
- R7: Writing 0 to bit 6 clears the clock-fail flag. Writing 1 to bit 6 leaves it unchanged.
- R8: postDiv equals 1, 4, 16 or 64 for a postscaler select of 00, 01, 10 or 11 respectively.
- R9: The lock status bit sets one edge after pllLock is high while the PLL (111) is current and no switch is pending. It clears when pllLock is low and on the edge at which a switch starts. It reads 0 whenever the current source is not 111.
- R10: The target of a pending switch is fixed when the switch starts. Rewriting the requested field during the switch changes only the readback of that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on / brown-out reset |
| cfgSrc | input | 3 | Configured source code loaded at reset |
| wrEn | input | 1 | Control word write strobe |
| byteEn | input | 2 | Byte enables for the write |
| wrData | input | 16 | Write data |
| srcReady | input | 8 | Per-code ready indication of each source, indexed by source code |
| pllLock | input | 1 | PLL lock indication |
| clkFail | input | 1 | Fail-safe monitor clock failure indication |
| rdData | output | 16 | Control word readback |
| postSel | output | 2 | Postscaler select |
| postDiv | output | 7 | Decoded postscaler divide ratio |

## Verification
The bench sweeps every source code as a switch target starting from fast RC. A design that decodes validity or equality wrongly would either move to an invalid code or hang with switch-enable stuck at 1. It samples the current source one cycle before and one cycle at the exact completion edge, and it drops ready in mid-count. An off-by-one settle counter, or one that does not restart when ready drops, therefore shows up directly. It also fires the fail monitor during a pending switch, rewrites the requested field during a switch, and watches the lock bit across a switch start while pllLock stays high. These catch a cancelled switch that completes later, a target that follows the live request field, and a lock bit that does not clear when the switch begins.

// File: rtl/cksw_pkg.sv
package cksw_pkg;
  localparam int SRC_W = 3;
  localparam int NUM_CODES = 1 << SRC_W;
  localparam int WORD_W = 16;
  localparam int DIV_W = 7;

  typedef logic [SRC_W-1:0] src_t;

  localparam src_t SRC_LPXTAL = 3'b000;
  localparam src_t SRC_FRC    = 3'b001;
  localparam src_t SRC_LPRC   = 3'b010;
  localparam src_t SRC_EXT    = 3'b011;
  localparam src_t SRC_PLL    = 3'b111;

  // control word bit positions
  localparam int REQ_LSB  = 0;
  localparam int SWEN_BIT = 3;
  localparam int POST_LSB = 4;
  localparam int FAIL_BIT = 6;
  localparam int LOCK_BIT = 7;
  localparam int CUR_LSB  = 8;

  typedef struct packed {
    logic startSw;
    logic abortSw;
    logic doneSw;
    logic cancelSw;
    logic busy;
    src_t target;
  } ctl_strb_t;

  function automatic logic srcValid(input src_t s);
    case (s)
      SRC_LPXTAL, SRC_FRC, SRC_LPRC, SRC_EXT, SRC_PLL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cksw_ctrl.sv
module cksw_ctrl
  import cksw_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swEn,
  input  src_t                 reqSrc,
  input  src_t                 curSrc,
  input  logic [NUM_CODES-1:0] srcReady,
  input  logic                 clkFail,
  output ctl_strb_t            strb
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_WAIT} state_t;

  state_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  src_t tgtQ, tgtD;

  always_comb begin
    strb        = '0;
    strb.target = tgtQ;
    strb.busy   = (stateQ == ST_WAIT);
    stateD      = stateQ;
    cntD        = cntQ;
    tgtD        = tgtQ;
    case (stateQ)
      ST_IDLE: begin
        if (swEn) begin
          if (!srcValid(reqSrc) || reqSrc == curSrc || clkFail) begin
            strb.abortSw = 1'b1;
          end else begin
            strb.startSw = 1'b1;
            tgtD         = reqSrc;
            cntD         = '0;
            stateD       = ST_WAIT;
          end
        end
      end
      default: begin
        if (clkFail) begin
          strb.cancelSw = 1'b1;
          stateD        = ST_IDLE;
        end else if (srcReady[tgtQ]) begin
          if (cntQ == CNT_LAST) begin
            strb.doneSw = 1'b1;
            stateD      = ST_IDLE;
          end else begin
            cntD = cntQ + 1'b1;
          end
        end else begin
          cntD = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      tgtQ   <= SRC_FRC;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      tgtQ   <= tgtD;
    end
  end
endmodule

// File: rtl/cksw_dpath.sv
module cksw_dpath
  import cksw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  src_t              cfgSrc,
  input  logic              wrEn,
  input  logic [1:0]        byteEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              pllLock,
  input  logic              clkFail,
  input  ctl_strb_t         strb,
  output src_t              reqSrc,
  output src_t              curSrc,
  output logic              swEn,
  output logic [WORD_W-1:0] rdData,
  output logic [1:0]        postSel,
  output logic [DIV_W-1:0]  postDiv
);
  logic failFlag, lockQ, wrLo, lockVis;
  logic unusedWrBits;

  assign wrLo = wrEn & byteEn[0];
  // upper byte holds only read-only fields
  assign unusedWrBits = ^{byteEn[1], wrData[WORD_W-1:LOCK_BIT]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc   <= cfgSrc;
      reqSrc   <= cfgSrc;
      swEn     <= 1'b0;
      postSel  <= 2'b00;
      failFlag <= 1'b0;
      lockQ    <= 1'b0;
    end else begin
      if (wrLo) begin
        reqSrc  <= wrData[REQ_LSB +: SRC_W];
        postSel <= wrData[POST_LSB +: 2];
        if (wrData[SWEN_BIT]) swEn <= 1'b1;
        if (!wrData[FAIL_BIT]) failFlag <= 1'b0;
      end
      if (strb.abortSw || strb.doneSw || strb.cancelSw) swEn <= 1'b0;
      if (clkFail) begin
        curSrc   <= SRC_FRC;
        failFlag <= 1'b1;
      end else if (strb.doneSw) begin
        curSrc <= strb.target;
      end
      if (strb.startSw || !pllLock) lockQ <= 1'b0;
      else if (curSrc == SRC_PLL && !strb.busy) lockQ <= 1'b1;
    end
  end

  assign lockVis = lockQ & (curSrc == SRC_PLL);

  always_comb begin
    rdData                       = '0;
    rdData[REQ_LSB +: SRC_W]     = reqSrc;
    rdData[SWEN_BIT]             = swEn;
    rdData[POST_LSB +: 2]        = postSel;
    rdData[FAIL_BIT]             = failFlag;
    rdData[LOCK_BIT]             = lockVis;
    rdData[CUR_LSB +: SRC_W]     = curSrc;
  end

  assign postDiv = DIV_W'(1) << {postSel, 1'b0};
endmodule

// File: rtl/cksw_top.sv
module cksw_top
  import cksw_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cfgSrc,
  input  logic        wrEn,
  input  logic [1:0]  byteEn,
  input  logic [15:0] wrData,
  input  logic [7:0]  srcReady,
  input  logic        pllLock,
  input  logic        clkFail,
  output logic [15:0] rdData,
  output logic [1:0]  postSel,
  output logic [6:0]  postDiv
);
  ctl_strb_t strb;
  src_t reqSrc, curSrc;
  logic swEn;

  cksw_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .swEn(swEn), .reqSrc(reqSrc), .curSrc(curSrc),
    .srcReady(srcReady), .clkFail(clkFail), .strb(strb)
  );

  cksw_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cfgSrc(cfgSrc), .wrEn(wrEn), .byteEn(byteEn),
    .wrData(wrData), .pllLock(pllLock), .clkFail(clkFail), .strb(strb),
    .reqSrc(reqSrc), .curSrc(curSrc), .swEn(swEn), .rdData(rdData),
    .postSel(postSel), .postDiv(postDiv)
  );
endmodule

// File: rtl/cksw_chk.sv
module cksw_chk
  import cksw_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] rdData,
  input logic        clkFail,
  input logic        pllLock,
  input logic [6:0]  postDiv,
  input ctl_strb_t   strb
);
  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:11] == 5'd0);

  assert_abort_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.abortSw |=> !rdData[3]);

  assert_done_loads_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneSw |=> (rdData[10:8] == $past(strb.target) && !rdData[3]));

  assert_cur_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData[10:8]) |-> ($past(clkFail) || $past(strb.doneSw)));

  assert_fail_to_frc_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkFail |=> (rdData[10:8] == 3'b001 && rdData[6] && !rdData[3]));

  assert_div_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(postDiv) == 1);

  assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[7]) |-> $past(pllLock));
endmodule

bind cksw_top cksw_chk u_chk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .clkFail(clkFail),
  .pllLock(pllLock), .postDiv(postDiv), .strb(strb)
);

// File: tb/sim_cksw_top.sv
`timescale 1ns/1ps
module sim_cksw_top;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cfgSrc = 3'b001;
  logic wrEn = 1'b0;
  logic [1:0] byteEn = 2'b00;
  logic [15:0] wrData = '0;
  logic [7:0] srcReady = '0;
  logic pllLock = 1'b0;
  logic clkFail = 1'b0;
  logic [15:0] rdData;
  logic [1:0] postSel;
  logic [6:0] postDiv;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  cksw_top #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .cfgSrc(cfgSrc), .wrEn(wrEn), .byteEn(byteEn),
    .wrData(wrData), .srcReady(srcReady), .pllLock(pllLock), .clkFail(clkFail),
    .rdData(rdData), .postSel(postSel), .postDiv(postDiv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [2:0] c);
    rstN = 1'b0;
    cfgSrc = c;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] be);
    wrEn = 1'b1; wrData = d; byteEn = be;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00;
  endtask

  task automatic failPulse();
    clkFail = 1'b1;
    @(negedge clk);
    clkFail = 1'b0;
  endtask

  function automatic int curF(); return int'(rdData[10:8]); endfunction
  function automatic int swF();  return int'(rdData[3]);    endfunction
  function automatic int failF(); return int'(rdData[6]);   endfunction
  function automatic int lockF(); return int'(rdData[7]);   endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state for every configured code
    for (int c = 0; c < 8; c++) begin
      doReset(3'(c));
      chk("R1 cur", curF(), c);
      chk("R1 req", int'(rdData[2:0]), c);
      chk("R1 other fields", int'(rdData[15:11]) + int'(rdData[7:3]), 0);
      chk("R1 postDiv", int'(postDiv), 1);
    end

    doReset(3'b001);
    // R2: read-only bits and unimplemented bits
    wr(16'hFFF7, 2'b11);
    chk("R2 readback", int'(rdData), 16'h0137);
    chk("R8 postDiv 64", int'(postDiv), 64);
    // R3: no write without byteEn[0]
    wr(16'h0000, 2'b10);
    chk("R3 upper-only write", int'(rdData), 16'h0137);
    wr(16'h0000, 2'b00);
    chk("R3 no enable", int'(rdData), 16'h0137);
    wr(16'h0000, 2'b01);
    chk("R3 low write", int'(rdData), 16'h0100);

    // R4/R5/R6/R7: sweep every target code from fast RC
    srcReady = 8'hFF;
    for (int c = 0; c < 8; c++) begin
      bit goes;
      goes = (c == 0 || c == 2 || c == 3 || c == 7);
      wr(16'(8 | c), 2'b01);
      waitN(1);
      chk(goes ? "R5 busy" : "R4 abort clears enable", swF(), goes ? 1 : 0);
      waitN(SETTLE - 1);
      chk("R5 not early", curF(), 1);
      waitN(1);
      chk(goes ? "R5 switched" : "R4 unchanged", curF(), goes ? c : 1);
      chk("R5 enable self-clears", swF(), 0);
      if (goes) begin
        failPulse();
        chk("R6 forced frc", curF(), 1);
        chk("R6 fail flag", failF(), 1);
        wr(16'h0041, 2'b01);
        chk("R7 write 1 keeps flag", failF(), 1);
        wr(16'h0001, 2'b01);
        chk("R7 write 0 clears flag", failF(), 0);
      end
    end

    // R8: postscaler sweep
    for (int p = 0; p < 4; p++) begin
      wr(16'((p << 4) | 1), 2'b01);
      chk("R8 postSel", int'(postSel), p);
      chk("R8 postDiv", int'(postDiv), 1 << (2 * p));
    end

    // R5: ready dropping mid-count restarts it
    srcReady = 8'h00;
    wr(16'h000B, 2'b01);
    waitN(1);
    srcReady = 8'h08;
    waitN(SETTLE - 1);
    srcReady = 8'h00;
    waitN(1);
    srcReady = 8'h08;
    waitN(SETTLE - 1);
    chk("R5 restart not early", curF(), 1);
    waitN(1);
    chk("R5 restart done", curF(), 3);

    // R6: fail cancels a pending switch
    srcReady = 8'h00;
    wr(16'h0008, 2'b01);
    waitN(1);
    failPulse();
    chk("R6 cancel cur", curF(), 1);
    chk("R6 cancel enable", swF(), 0);
    srcReady = 8'hFF;
    waitN(SETTLE + 2);
    chk("R6 cancelled stays", curF(), 1);
    wr(16'h0001, 2'b01);

    // R10: target fixed at start
    srcReady = 8'h00;
    wr(16'h000B, 2'b01);
    waitN(1);
    wr(16'h0008, 2'b01);
    srcReady = 8'hFF;
    waitN(SETTLE);
    chk("R10 target kept", curF(), 3);
    chk("R10 req readback", int'(rdData[2:0]), 0);

    // R9: lock status
    wr(16'h000F, 2'b01);
    waitN(SETTLE + 1);
    chk("R9 on pll", curF(), 7);
    chk("R9 no lock yet", lockF(), 0);
    pllLock = 1'b1;
    waitN(1);
    chk("R9 lock set", lockF(), 1);
    pllLock = 1'b0;
    waitN(1);
    chk("R9 lock lost", lockF(), 0);
    pllLock = 1'b1;
    waitN(1);
    chk("R9 relock", lockF(), 1);
    srcReady = 8'h00;
    wr(16'h0009, 2'b01);
    waitN(1);
    chk("R9 start clears lock", lockF(), 0);
    chk("R9 still pll", curF(), 7);
    srcReady = 8'hFF;
    waitN(SETTLE);
    chk("R9 left pll", curF(), 1);
    chk("R9 lock reads 0 off pll", lockF(), 0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule